// File: doc/BRIEF.md
# Shared RX/TX Crypto Engine Allocator

A storage host controller carries a pool of identical crypto engines. Write traffic leaving the host is encrypted on its way out (the transmit, or TX, side). Read traffic arriving at the host is decrypted (the receive, or RX, side). This block chooses which engines each side owns.

There are two operating modes:

- **Static mode.** Each direction keeps its own fixed half of the pool. A direction uses its half only while it is active, so the half that belongs to an idle direction sits unused.
- **Shared mode.** The number of engines given to each side depends on which traffic is in progress: reads only, writes only, or both. The counts come from a packed configuration register.

Two level inputs say whether a read data block and a write data block are currently in progress. The block drives one ownership bit per engine for each direction, together with the number of engines each direction holds.

An engine that must change sides is first released, and only when it reports idle. It is handed to the other side one cycle later. Software sets the mode and the counts through a small write port. The block captures both registers only when the read/write activity combination changes, so an allocation already in force never moves because of a register write alone.

Top module: `crypto_alloc_top`

## Requirements
- R1: After reset no engine is owned by either direction, both grant counts are 0, the block is in static mode, and the count register holds byte0=28, byte1=28, byte2=15, byte3=13.
- R2: In static mode an active read side owns exactly 14 engines and an active write side owns exactly 14 engines. Each side does this whatever the other side is doing.
- R3: A write of the value 2 to the mode register (select 0) chooses shared mode. Any other value chooses static mode.
- R4: The count register (select 1) is read as four bytes, least significant first. Byte0 is the RX count with reads only. Byte1 is the TX count with writes only. Byte2 is the RX count with both active. Byte3 is the TX count with both active.
- R5: RX always takes the lowest-numbered engines (0 upward) and TX always takes the highest-numbered engines (27 downward).
- R6: A count above the pool size (28) is clamped to 28. With both sides active, the TX count is clamped further to 28 minus the granted RX count, so the two grants never add up to more than 28.
- R7: When neither reads nor writes are active, the target for both sides is 0. Every engine is released once it is idle, and no new ownership is given.
- R8: An owned engine that is no longer wanted is released only in a cycle in which its idle input is high. An engine is never owned by one direction in the cycle right after it was owned by the other.
- R9: Writes to the mode or count register have no effect on ownership until the next change in the read/write activity combination.
- R10: A change on the activity inputs is registered on the first clock edge. Engines that are free take their new ownership on the second edge. An engine that first has to be released is released on the second edge and re-owned on the third. The grant outputs follow the ownership bits in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_active | input | 1 | A read data block is in progress (RX side busy) |
| wr_active | input | 1 | A write data block is in progress (TX side busy) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 = mode, 1 = packed counts |
| cfg_wdata | input | 32 | Configuration write data |
| eng_idle | input | 28 | One bit per engine: high when that engine holds no work in flight |
| eng_rx_own | output | 28 | One bit per engine: high when the RX side owns that engine |
| eng_tx_own | output | 28 | One bit per engine: high when the TX side owns that engine |
| rx_grant | output | 5 | Number of engines the RX side owns |
| tx_grant | output | 5 | Number of engines the TX side owns |

## Verification
- **Timing of the checks.** Inputs are driven on the falling edge, and outputs are sampled on a falling edge after a known number of rising edges.
- **Free engines.** Ownership is checked exactly two rising edges after an activity change.
- **Engines that change sides.** These are checked at the second edge, when only the release has happened, and again at the third edge, when the other side holds them.
- **Held engines.** With the idle inputs held low, the checks look several cycles past the normal due cycle and confirm that nothing has moved.
- **Deferred register writes.** These are checked a few cycles after the write, before any activity change, and again two edges after the change that applies them.

// File: rtl/crypto_alloc_pkg.sv
package crypto_alloc_pkg;

    typedef enum logic [1:0] {
        OWN_FREE = 2'd0,
        OWN_RX   = 2'd1,
        OWN_TX   = 2'd2
    } owner_e;

    // Mode register value that enables the shared pool
    localparam int unsigned SHARED_CODE = 2;

    // Byte slots inside the packed count register
    localparam int unsigned SLOT_RD_ONLY = 0;
    localparam int unsigned SLOT_WR_ONLY = 1;
    localparam int unsigned SLOT_BOTH_RX = 2;
    localparam int unsigned SLOT_BOTH_TX = 3;

endpackage

// File: rtl/crypto_alloc_cfg.sv
module crypto_alloc_cfg
    import crypto_alloc_pkg::*;
#(
    parameter  int unsigned NUM_ENG = 28,
    parameter  int unsigned CNT_W   = 8,
    localparam int unsigned DATA_W  = 4 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              rd_active,
    input  logic              wr_active,
    output logic [1:0]        act_o,
    output logic              shared_o,
    output logic [DATA_W-1:0] cnt_o
);

    localparam int unsigned BOTH_RX_DEF = (NUM_ENG * 15) / 28;

    localparam logic [CNT_W-1:0] RST_SOLO    = CNT_W'(NUM_ENG);
    localparam logic [CNT_W-1:0] RST_BOTH_RX = CNT_W'(BOTH_RX_DEF);
    localparam logic [CNT_W-1:0] RST_BOTH_TX = CNT_W'(NUM_ENG - BOTH_RX_DEF);

    localparam logic [DATA_W-1:0] RST_CNT = {RST_BOTH_TX, RST_BOTH_RX, RST_SOLO, RST_SOLO};

    typedef struct packed {
        logic [1:0]        act;
        logic              shared_live;
        logic [DATA_W-1:0] cnt_live;
        logic              shared_snap;
        logic [DATA_W-1:0] cnt_snap;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        if (cfg_we) begin
            if (!cfg_sel) begin
                st_d.shared_live = (cfg_wdata == DATA_W'(SHARED_CODE));
            end else begin
                st_d.cnt_live = cfg_wdata;
            end
        end

        // Register contents are captured only when the activity combination changes
        if ({wr_active, rd_active} != st_q.act) begin
            st_d.act         = {wr_active, rd_active};
            st_d.shared_snap = st_d.shared_live;
            st_d.cnt_snap    = st_d.cnt_live;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{act: 2'b00, shared_live: 1'b0, cnt_live: RST_CNT,
                      shared_snap: 1'b0, cnt_snap: RST_CNT};
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o    = st_q.act;
    assign shared_o = st_q.shared_snap;
    assign cnt_o    = st_q.cnt_snap;

endmodule

// File: rtl/crypto_alloc_target.sv
module crypto_alloc_target
    import crypto_alloc_pkg::*;
#(
    parameter  int unsigned NUM_ENG = 28,
    parameter  int unsigned CNT_W   = 8,
    localparam int unsigned IDX_W   = $clog2(NUM_ENG + 1),
    localparam int unsigned DATA_W  = 4 * CNT_W
) (
    input  logic [1:0]        act,
    input  logic              shared,
    input  logic [DATA_W-1:0] cnt,
    output logic [IDX_W-1:0]  rx_t,
    output logic [IDX_W-1:0]  tx_t
);

    localparam int unsigned HALF = NUM_ENG / 2;

    function automatic logic [IDX_W-1:0] clamp(input logic [CNT_W-1:0] c, input int unsigned lim);
        int unsigned cv;
        cv = int'(c);
        if (cv > lim) begin
            return IDX_W'(lim);
        end
        return IDX_W'(cv);
    endfunction

    logic [CNT_W-1:0] c_rd, c_wr, c_brx, c_btx;

    assign c_rd  = cnt[SLOT_RD_ONLY*CNT_W +: CNT_W];
    assign c_wr  = cnt[SLOT_WR_ONLY*CNT_W +: CNT_W];
    assign c_brx = cnt[SLOT_BOTH_RX*CNT_W +: CNT_W];
    assign c_btx = cnt[SLOT_BOTH_TX*CNT_W +: CNT_W];

    always_comb begin
        rx_t = '0;
        tx_t = '0;

        if (!shared) begin
            if (act[0]) rx_t = IDX_W'(HALF);
            if (act[1]) tx_t = IDX_W'(NUM_ENG - HALF);
        end else begin
            case (act)
                2'b01: rx_t = clamp(c_rd, NUM_ENG);
                2'b10: tx_t = clamp(c_wr, NUM_ENG);
                2'b11: begin
                    rx_t = clamp(c_brx, NUM_ENG);
                    tx_t = clamp(c_btx, NUM_ENG - int'(rx_t));
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/crypto_alloc_slot.sv
module crypto_alloc_slot
    import crypto_alloc_pkg::*;
#(
    parameter int unsigned NUM_ENG = 28,
    parameter int unsigned IDX     = 0,
    parameter int unsigned IDX_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rx_t,
    input  logic [IDX_W-1:0] tx_t,
    input  logic             idle,
    output logic             own_rx,
    output logic             own_tx
);

    localparam logic [IDX_W:0] POS = (IDX_W + 1)'(IDX);
    localparam logic [IDX_W:0] TOP = (IDX_W + 1)'(NUM_ENG);

    typedef struct packed {
        owner_e owner;
    } slot_state_t;

    slot_state_t st_d, st_q;

    logic   want_rx, want_tx;
    owner_e desired;

    // RX fills from engine 0 upward; TX fills from the last engine downward
    assign want_rx = POS < {1'b0, rx_t};
    assign want_tx = (POS + {1'b0, tx_t}) >= TOP;

    always_comb begin
        desired = OWN_FREE;
        if (want_rx) begin
            desired = OWN_RX;
        end else if (want_tx) begin
            desired = OWN_TX;
        end

        st_d = st_q;
        if (st_q.owner != desired) begin
            if (st_q.owner == OWN_FREE) begin
                st_d.owner = desired;
            end else if (idle) begin
                st_d.owner = OWN_FREE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{owner: OWN_FREE};
        end else begin
            st_q <= st_d;
        end
    end

    assign own_rx = (st_q.owner == OWN_RX);
    assign own_tx = (st_q.owner == OWN_TX);

endmodule

// File: rtl/crypto_alloc_top.sv
module crypto_alloc_top
    import crypto_alloc_pkg::*;
#(
    parameter  int unsigned NUM_ENG = 28,
    parameter  int unsigned CNT_W   = 8,
    localparam int unsigned IDX_W   = $clog2(NUM_ENG + 1),
    localparam int unsigned DATA_W  = 4 * CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_active,
    input  logic               wr_active,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  logic [NUM_ENG-1:0] eng_idle,
    output logic [NUM_ENG-1:0] eng_rx_own,
    output logic [NUM_ENG-1:0] eng_tx_own,
    output logic [IDX_W-1:0]   rx_grant,
    output logic [IDX_W-1:0]   tx_grant
);

    logic [1:0]        act;
    logic              shared;
    logic [DATA_W-1:0] cnt;
    logic [IDX_W-1:0]  rx_t, tx_t;

    crypto_alloc_cfg #(.NUM_ENG(NUM_ENG), .CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .rd_active (rd_active),
        .wr_active (wr_active),
        .act_o     (act),
        .shared_o  (shared),
        .cnt_o     (cnt)
    );

    crypto_alloc_target #(.NUM_ENG(NUM_ENG), .CNT_W(CNT_W)) u_target (
        .act    (act),
        .shared (shared),
        .cnt    (cnt),
        .rx_t   (rx_t),
        .tx_t   (tx_t)
    );

    for (genvar g = 0; g < NUM_ENG; g++) begin : g_slot
        crypto_alloc_slot #(.NUM_ENG(NUM_ENG), .IDX(g), .IDX_W(IDX_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .rx_t   (rx_t),
            .tx_t   (tx_t),
            .idle   (eng_idle[g]),
            .own_rx (eng_rx_own[g]),
            .own_tx (eng_tx_own[g])
        );
    end

    always_comb begin
        rx_grant = '0;
        tx_grant = '0;
        for (int i = 0; i < NUM_ENG; i++) begin
            rx_grant = rx_grant + IDX_W'(eng_rx_own[i]);
            tx_grant = tx_grant + IDX_W'(eng_tx_own[i]);
        end
    end

endmodule

// File: rtl/crypto_alloc_checker.sv
module crypto_alloc_checker #(
    parameter int unsigned NUM_ENG = 28,
    parameter int unsigned IDX_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_active,
    input logic               wr_active,
    input logic [NUM_ENG-1:0] eng_idle,
    input logic [NUM_ENG-1:0] eng_rx_own,
    input logic [NUM_ENG-1:0] eng_tx_own,
    input logic [IDX_W-1:0]   rx_grant,
    input logic [IDX_W-1:0]   tx_grant
);

    // R6: the two grants together never exceed the pool
    p_pool_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rx_grant) + int'(tx_grant)) <= int'(NUM_ENG));

    // R7: new RX ownership only follows a sampled active read
    p_no_new_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(eng_rx_own & ~$past(eng_rx_own))) |-> $past(rd_active));

    // R7: new TX ownership only follows a sampled active write
    p_no_new_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(eng_tx_own & ~$past(eng_tx_own))) |-> $past(wr_active));

    // R8: ownership is dropped only by an engine that was idle
    p_release_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(eng_rx_own) & ~eng_rx_own) | ($past(eng_tx_own) & ~eng_tx_own))
         & ~$past(eng_idle)) == '0);

    // R8: no engine passes directly from one direction to the other
    p_no_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(eng_rx_own) & eng_tx_own) | ($past(eng_tx_own) & eng_rx_own)) == '0);

endmodule

bind crypto_alloc_top crypto_alloc_checker #(.NUM_ENG(NUM_ENG), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_active  (rd_active),
    .wr_active  (wr_active),
    .eng_idle   (eng_idle),
    .eng_rx_own (eng_rx_own),
    .eng_tx_own (eng_tx_own),
    .rx_grant   (rx_grant),
    .tx_grant   (tx_grant)
);

// File: tb/crypto_alloc_top_test.sv
module crypto_alloc_top_test;

    localparam int unsigned N     = 28;
    localparam int unsigned IDX_W = $clog2(N + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rd_active = 1'b0;
    logic             wr_active = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_sel = 1'b0;
    logic [31:0]      cfg_wdata = '0;
    logic [N-1:0]     eng_idle = '1;
    logic [N-1:0]     eng_rx_own, eng_tx_own;
    logic [IDX_W-1:0] rx_grant, tx_grant;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    crypto_alloc_top #(.NUM_ENG(N), .CNT_W(8)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_active  (rd_active),
        .wr_active  (wr_active),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .eng_idle   (eng_idle),
        .eng_rx_own (eng_rx_own),
        .eng_tx_own (eng_tx_own),
        .rx_grant   (rx_grant),
        .tx_grant   (tx_grant)
    );

    function automatic logic [31:0] lo_mask(input int unsigned n);
        return (32'd1 << n) - 32'd1;
    endfunction

    function automatic logic [31:0] hi_mask(input int unsigned n);
        return lo_mask(n) << (N - n);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_state(input string req, input int unsigned rxn, input logic [31:0] rxm,
                                input int unsigned txn, input logic [31:0] txm);
        check(req, "rx_grant", 32'(rx_grant), 32'(rxn));
        check(req, "tx_grant", 32'(tx_grant), 32'(txn));
        check(req, "eng_rx_own", 32'(eng_rx_own), rxm);
        check(req, "eng_tx_own", 32'(eng_tx_own), txm);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic sel, input logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        step(1);
        cfg_we = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset;
        expect_state("R1", 0, 0, 0, 0);
    endtask

    // R2/R10: static split with latency
    task automatic t_static;
        rd_active = 1'b1;
        step(1);
        expect_state("R10", 0, 0, 0, 0);
        step(1);
        expect_state("R2", 14, lo_mask(14), 0, 0);
        wr_active = 1'b1;
        step(2);
        expect_state("R2", 14, lo_mask(14), 14, hi_mask(14));
        rd_active = 1'b0; wr_active = 1'b0;
        step(2);
        expect_state("R7", 0, 0, 0, 0);
    endtask

    // R3/R4: shared mode with reset counts (byte0=28)
    task automatic t_shared_rd;
        cfg_write(1'b0, 32'd2);
        rd_active = 1'b1;
        step(2);
        expect_state("R3", 28, lo_mask(28), 0, 0);
    endtask

    // R9/R8/R5: deferred count write, then both-active split through release
    task automatic t_both_split;
        cfg_write(1'b1, 32'h0D0F1C0A);
        step(3);
        expect_state("R9", 28, lo_mask(28), 0, 0);
        wr_active = 1'b1;
        step(2);
        expect_state("R8", 15, lo_mask(15), 0, 0);
        step(1);
        expect_state("R5", 15, lo_mask(15), 13, hi_mask(13));
    endtask

    // R8: busy engines are held until idle
    task automatic t_hold_busy;
        eng_idle = ~N'(lo_mask(15));
        rd_active = 1'b0;
        step(5);
        expect_state("R8", 15, lo_mask(15), 13, hi_mask(13));
        eng_idle = '1;
        step(1);
        expect_state("R8", 0, 0, 13, hi_mask(13));
        step(1);
        expect_state("R4", 0, 0, 28, lo_mask(28));
    endtask

    // R6: saturation of counts above the pool
    task automatic t_saturate;
        cfg_write(1'b1, 32'h1428320A);
        wr_active = 1'b0;
        step(2);
        expect_state("R7", 0, 0, 0, 0);
        rd_active = 1'b1; wr_active = 1'b1;
        step(2);
        expect_state("R6", 28, lo_mask(28), 0, 0);
        rd_active = 1'b0;
        step(3);
        expect_state("R6", 0, 0, 28, lo_mask(28));
        wr_active = 1'b0;
        step(2);
        expect_state("R7", 0, 0, 0, 0);
    endtask

    // R4: byte0 drives the reads-only RX count
    task automatic t_byte0;
        rd_active = 1'b1;
        step(2);
        expect_state("R4", 10, lo_mask(10), 0, 0);
    endtask

    // R9/R3: mode change deferred, non-2 value returns to static
    task automatic t_back_static;
        cfg_write(1'b0, 32'd0);
        step(3);
        expect_state("R9", 10, lo_mask(10), 0, 0);
        rd_active = 1'b0;
        step(2);
        expect_state("R7", 0, 0, 0, 0);
        rd_active = 1'b1;
        step(2);
        expect_state("R3", 14, lo_mask(14), 0, 0);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_static();
        t_shared_rd();
        t_both_split();
        t_hold_busy();
        t_saturate();
        t_byte0();
        t_back_static();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

endmodule